// File: doc/BRIEF.md
# Sync-Hunting Sample Record Parser

This block sits behind a byte-oriented serial receiver and rebuilds fixed five-byte sample records from the byte stream. Bytes arrive as a data byte qualified by a valid strobe. They are gathered in a small window. The parser aligns to a sync byte, checks the stream identifier and the flag byte, and then unpacks a signed 16-bit sample and a one-bit detection flag for each good record. Each accepted record is announced with a one-cycle valid pulse.

The link has no flow control, so alignment can be lost at any time. When the oldest byte in the window is not the sync value, the parser drops that byte alone and looks again. It never throws away a whole record-sized block. A record that starts with the sync value but carries a wrong identifier or an illegal flag byte is also rejected one byte at a time, which lets a true record hidden inside it be found. Three saturating counters count the bytes dropped while hunting, the identifier rejections and the flag rejections.

Top module: `rec_sync_parser`

## Requirements
- R1: A record is accepted when its bytes, in arrival order, are 0xEC (sync), 0x71 (stream ID), sample low byte, sample high byte, and a flag byte equal to 0x00 or 0x01. On acceptance, rec_sample equals {byte 3, byte 2} as two's complement and rec_flag equals bit 0 of byte 4.
- R2: rec_valid is high for exactly one cycle per accepted record. It rises in the clock cycle after the edge that captures the fifth byte.
- R3: rec_sample and rec_flag keep their values in every cycle in which rec_valid is low.
- R4: While the oldest buffered byte is not 0xEC, the parser drops that one byte per cycle and increments sync_drop_cnt by one for each byte dropped.
- R5: A full window led by 0xEC whose second byte is not 0x71 is rejected. The parser increments id_err_cnt and drops only the leading byte, so a record that starts later in those bytes is still found.
- R6: A full window led by 0xEC and 0x71 whose fifth byte is neither 0x00 nor 0x01 is rejected. The parser increments flag_err_cnt and drops only the leading byte.
- R7: A byte that arrives in the same cycle as a one-byte drop or a record acceptance is kept, so back-to-back records with no idle cycles are all recovered.
- R8: Each error counter stops at its all-ones value and never wraps.
- R9: A synchronous active-high reset empties the window, clears all counters, rec_sample and rec_flag, and holds rec_valid low. Bytes captured before the reset never contribute to a later record.
- R10: in_data has no effect while in_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | in_data holds a received byte this cycle |
| in_data | input | 8 | Received byte |
| rec_valid | output | 1 | One-cycle pulse for an accepted record |
| rec_sample | output | 16 | Signed sample of the last accepted record |
| rec_flag | output | 1 | Detection flag of the last accepted record |
| sync_drop_cnt | output | CNT_W | Bytes dropped while hunting for sync |
| id_err_cnt | output | CNT_W | Records rejected for a wrong stream ID |
| flag_err_cnt | output | CNT_W | Records rejected for an illegal flag byte |

## Verification
Removing a byte from the front of the window and appending a newly received byte can happen in the same cycle. This occurs both when a stray byte is dropped and when a complete record is accepted and the window is emptied. The bench provokes this by sending bytes on consecutive cycles: a stray byte directly followed by two records with no gap, and a random stream of clean records, garbage and damaged records with idle gaps of zero to two cycles. It judges the result by comparing every emitted record and every final counter value with a byte-level reference model in the bench. A lost or doubled byte in the shared cycle changes the record list or the counts.

// File: rtl/recpar_pkg.sv
package recpar_pkg;

  localparam int BYTE_W    = 8;
  localparam int REC_BYTES = 5;
  localparam int SAMPLE_W  = 16;

  // byte positions inside a record, oldest byte at 0
  localparam int POS_SYNC  = 0;
  localparam int POS_ID    = 1;
  localparam int POS_LO    = 2;
  localparam int POS_HI    = 3;
  localparam int POS_FLAG  = 4;

  // error counter slots
  localparam int NUM_ERR   = 3;
  localparam int ERR_SYNC  = 0;
  localparam int ERR_ID    = 1;
  localparam int ERR_FLAG  = 2;

  typedef enum logic [2:0] {
    V_WAIT      = 3'd0,
    V_ACCEPT    = 3'd1,
    V_SYNC_DROP = 3'd2,
    V_ID_BAD    = 3'd3,
    V_FLAG_BAD  = 3'd4
  } verdict_e;

endpackage

// File: rtl/recpar_window.sv
module recpar_window #(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 5,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          push,
  input  logic [BYTE_W-1:0]             push_byte,
  input  logic                          drop_one,
  input  logic                          drop_all,
  output logic [DEPTH-1:0][BYTE_W-1:0]  win,
  output logic [FILL_W-1:0]             fill
);

  logic [DEPTH-1:0][BYTE_W-1:0] shifted;
  logic [DEPTH-1:0][BYTE_W-1:0] win_nxt;
  logic [FILL_W-1:0]            fill_after;
  logic [FILL_W-1:0]            fill_nxt;

  // remove from the front first, then append behind what is left
  always_comb begin
    shifted    = win;
    fill_after = fill;
    if (drop_all) begin
      fill_after = '0;
    end else if (drop_one) begin
      shifted    = win >> BYTE_W;
      fill_after = fill - FILL_W'(1);
    end
    win_nxt = shifted;
    if (push) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (FILL_W'(i) == fill_after) win_nxt[i] = push_byte;
      end
    end
    fill_nxt = fill_after + FILL_W'(push);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win  <= '0;
      fill <= '0;
    end else begin
      win  <= win_nxt;
      fill <= fill_nxt;
    end
  end

endmodule

// File: rtl/recpar_judge.sv
module recpar_judge
  import recpar_pkg::*;
#(
  parameter int          FILL_W   = 3,
  parameter logic [7:0]  SYNC_VAL = 8'hEC,
  parameter logic [7:0]  ID_VAL   = 8'h71
) (
  input  logic [REC_BYTES-1:0][BYTE_W-1:0] win,
  input  logic [FILL_W-1:0]                fill,
  output verdict_e                         verdict,
  output logic [SAMPLE_W-1:0]              sample,
  output logic                             flag_bit
);

  logic flag_legal;

  assign flag_legal = (win[POS_FLAG][BYTE_W-1:1] == '0);
  assign sample     = {win[POS_HI], win[POS_LO]};
  assign flag_bit   = win[POS_FLAG][0];

  always_comb begin
    if (fill == '0)
      verdict = V_WAIT;
    else if (win[POS_SYNC] != SYNC_VAL)
      verdict = V_SYNC_DROP;
    else if (fill != FILL_W'(REC_BYTES))
      verdict = V_WAIT;
    else if (win[POS_ID] != ID_VAL)
      verdict = V_ID_BAD;
    else if (!flag_legal)
      verdict = V_FLAG_BAD;
    else
      verdict = V_ACCEPT;
  end

endmodule

// File: rtl/recpar_errcnt.sv
module recpar_errcnt #(
  parameter int N     = 3,
  parameter int CNT_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N-1:0]               bump,
  output logic [N-1:0][CNT_W-1:0]    cnt
);

  for (genvar g = 0; g < N; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)
        cnt[g] <= '0;
      else if (bump[g] && (cnt[g] != {CNT_W{1'b1}}))
        cnt[g] <= cnt[g] + CNT_W'(1);
    end
  end

endmodule

// File: rtl/rec_sync_parser.sv
module rec_sync_parser
  import recpar_pkg::*;
#(
  parameter int         CNT_W    = 16,
  parameter logic [7:0] SYNC_VAL = 8'hEC,
  parameter logic [7:0] ID_VAL   = 8'h71
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [7:0]                 in_data,
  output logic                       rec_valid,
  output logic signed [15:0]         rec_sample,
  output logic                       rec_flag,
  output logic [CNT_W-1:0]           sync_drop_cnt,
  output logic [CNT_W-1:0]           id_err_cnt,
  output logic [CNT_W-1:0]           flag_err_cnt
);

  localparam int FILL_W = $clog2(REC_BYTES + 1);

  logic [REC_BYTES-1:0][BYTE_W-1:0] win;
  logic [FILL_W-1:0]                fill;
  verdict_e                         verdict;
  logic [SAMPLE_W-1:0]              cand_sample;
  logic                             cand_flag;
  logic                             take;
  logic                             slide;
  logic [NUM_ERR-1:0]               bump;
  logic [NUM_ERR-1:0][CNT_W-1:0]    cnt;

  recpar_window #(.BYTE_W(BYTE_W), .DEPTH(REC_BYTES)) u_win (
    .clk       (clk),
    .rst       (rst),
    .push      (in_valid),
    .push_byte (in_data),
    .drop_one  (slide),
    .drop_all  (take),
    .win       (win),
    .fill      (fill)
  );

  recpar_judge #(.FILL_W(FILL_W), .SYNC_VAL(SYNC_VAL), .ID_VAL(ID_VAL)) u_judge (
    .win      (win),
    .fill     (fill),
    .verdict  (verdict),
    .sample   (cand_sample),
    .flag_bit (cand_flag)
  );

  assign take  = (verdict == V_ACCEPT);
  assign slide = (verdict == V_SYNC_DROP) || (verdict == V_ID_BAD) ||
                 (verdict == V_FLAG_BAD);

  always_comb begin
    bump           = '0;
    bump[ERR_SYNC] = (verdict == V_SYNC_DROP);
    bump[ERR_ID]   = (verdict == V_ID_BAD);
    bump[ERR_FLAG] = (verdict == V_FLAG_BAD);
  end

  recpar_errcnt #(.N(NUM_ERR), .CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .bump (bump),
    .cnt  (cnt)
  );

  assign sync_drop_cnt = cnt[ERR_SYNC];
  assign id_err_cnt    = cnt[ERR_ID];
  assign flag_err_cnt  = cnt[ERR_FLAG];

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_valid  <= 1'b0;
      rec_sample <= '0;
      rec_flag   <= 1'b0;
    end else begin
      rec_valid <= take;
      if (take) begin
        rec_sample <= cand_sample;
        rec_flag   <= cand_flag;
      end
    end
  end

endmodule

// File: rtl/recpar_checker.sv
module recpar_checker #(
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               rec_valid,
  input logic [15:0]        rec_sample,
  input logic               rec_flag,
  input logic [CNT_W-1:0]   sync_drop_cnt,
  input logic [CNT_W-1:0]   id_err_cnt,
  input logic [CNT_W-1:0]   flag_err_cnt
);

  // R2: a record occupies a full window, so pulses never touch
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    rec_valid |=> !rec_valid);

  // R3: decoded fields move only with a pulse
  assert_hold_fields_R3: assert property (@(posedge clk) disable iff (rst)
    !rec_valid |-> ($stable(rec_sample) && $stable(rec_flag)));

  // R4 / R8: hunting counter never goes down (a wrap would)
  assert_sync_cnt_mono_R8: assert property (@(posedge clk) disable iff (rst)
    $past(sync_drop_cnt) <= sync_drop_cnt);

  // R5: identifier rejections counted at most one per cycle
  assert_id_cnt_step_R5: assert property (@(posedge clk) disable iff (rst)
    (id_err_cnt - $past(id_err_cnt)) <= CNT_W'(1));

  // R6: flag rejections counted at most one per cycle
  assert_flag_cnt_step_R6: assert property (@(posedge clk) disable iff (rst)
    (flag_err_cnt - $past(flag_err_cnt)) <= CNT_W'(1));

  // R1: an accepted window cannot also be a rejected one
  assert_accept_no_reject_R1: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> ($stable(id_err_cnt) && $stable(flag_err_cnt)));

  // R9: reset clears the visible state
  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> (!rec_valid && sync_drop_cnt == '0 && id_err_cnt == '0 &&
             flag_err_cnt == '0));

endmodule

bind rec_sync_parser recpar_checker #(.CNT_W(CNT_W)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .rec_valid     (rec_valid),
  .rec_sample    (rec_sample),
  .rec_flag      (rec_flag),
  .sync_drop_cnt (sync_drop_cnt),
  .id_err_cnt    (id_err_cnt),
  .flag_err_cnt  (flag_err_cnt)
);

// File: tb/rec_sync_parser_tb_top.sv
module rec_sync_parser_tb_top;

  localparam int CW   = 6;
  localparam int CMAX = (1 << CW) - 1;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic [7:0]         in_data = 8'h00;
  logic               rec_valid;
  logic signed [15:0] rec_sample;
  logic               rec_flag;
  logic [CW-1:0]      sync_drop_cnt, id_err_cnt, flag_err_cnt;

  rec_sync_parser #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .rec_valid(rec_valid), .rec_sample(rec_sample), .rec_flag(rec_flag),
    .sync_drop_cnt(sync_drop_cnt), .id_err_cnt(id_err_cnt),
    .flag_err_cnt(flag_err_cnt)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [16:0] got_q[$];
  logic [16:0] exp_q[$];
  logic [7:0]  sent_q[$];

  always @(negedge clk)
    if (!rst && rec_valid) got_q.push_back({rec_flag, rec_sample});

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    sent_q.push_back(b);
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 8'($urandom);   // R10 noise while idle
  endtask

  task automatic send5(input logic [7:0] a, b, c, d, e);
    send_byte(a); send_byte(b); send_byte(c); send_byte(d); send_byte(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    idle(2);
    rst = 1'b0;
    got_q.delete();
    sent_q.delete();
  endtask

  function automatic int sat(input int v);
    return (v < CMAX) ? v + 1 : CMAX;
  endfunction

  // byte-level reference built from the requirements
  task automatic run_model(output int s_cnt, output int i_cnt, output int f_cnt);
    logic [7:0] b[$];
    bit go;
    exp_q.delete();
    s_cnt = 0; i_cnt = 0; f_cnt = 0;
    foreach (sent_q[k]) begin
      b.push_back(sent_q[k]);
      go = 1'b1;
      while (go) begin
        if (b.size() == 0) go = 1'b0;
        else if (b[0] != 8'hEC) begin s_cnt = sat(s_cnt); void'(b.pop_front()); end
        else if (b.size() < 5) go = 1'b0;
        else if (b[1] != 8'h71) begin i_cnt = sat(i_cnt); void'(b.pop_front()); end
        else if (b[4] > 8'h01) begin f_cnt = sat(f_cnt); void'(b.pop_front()); end
        else begin
          exp_q.push_back({b[4][0], b[3], b[2]});
          b.delete();
          go = 1'b0;
        end
      end
    end
  endtask

  task automatic compare_model(input string tag);
    int s, i, f;
    run_model(s, i, f);
    chk(got_q.size() == exp_q.size(), {tag, " record count"}, got_q.size(), exp_q.size());
    for (int k = 0; k < got_q.size() && k < exp_q.size(); k++)
      chk(got_q[k] == exp_q[k], {tag, " record"}, int'(got_q[k]), int'(exp_q[k]));
    chk(int'(sync_drop_cnt) == s, {tag, " sync drops R4"}, sync_drop_cnt, s);
    chk(int'(id_err_cnt) == i, {tag, " id errors R5"}, id_err_cnt, i);
    chk(int'(flag_err_cnt) == f, {tag, " flag errors R6"}, flag_err_cnt, f);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 200000, 0);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A1C));
    idle(2);
    do_reset();

    // R9: reset state
    chk(rec_valid == 1'b0, "R9 rec_valid after reset", rec_valid, 0);
    chk(rec_sample == 16'sd0 && rec_flag == 1'b0, "R9 fields after reset", rec_sample, 0);
    chk(sync_drop_cnt == 0 && id_err_cnt == 0 && flag_err_cnt == 0,
        "R9 counters after reset", sync_drop_cnt, 0);

    // R1 / R2 / R3: clean record, latency and hold
    send5(8'hEC, 8'h71, 8'h34, 8'h12, 8'h01);
    chk(rec_valid == 1'b0, "R2 no pulse at capture edge", rec_valid, 0);
    @(negedge clk);
    chk(rec_valid == 1'b1, "R2 pulse one cycle later", rec_valid, 1);
    chk(rec_sample == 16'sh1234, "R1 sample little-endian", rec_sample, 16'h1234);
    chk(rec_flag == 1'b1, "R1 flag", rec_flag, 1);
    @(negedge clk);
    chk(rec_valid == 1'b0, "R2 pulse width one", rec_valid, 0);
    idle(4);
    chk(rec_sample == 16'sh1234 && rec_flag == 1'b1, "R3 fields held", rec_sample, 16'h1234);
    send5(8'hEC, 8'h71, 8'h00, 8'h80, 8'h00);
    idle(2);
    chk(rec_sample == -16'sd32768 && rec_flag == 1'b0, "R1 negative sample", rec_sample, 16'h8000);

    // R4: two stray bytes before a record
    do_reset();
    send_byte(8'h12); send_byte(8'h34);
    send5(8'hEC, 8'h71, 8'h0F, 8'h00, 8'h00);
    idle(6);
    chk(sync_drop_cnt == 2, "R4 sync drops", sync_drop_cnt, 2);
    chk(got_q.size() == 1 && got_q[0] == 17'h0000F, "R4 record after hunt",
        got_q.size(), 1);

    // R5: wrong identifier hides a shifted record
    do_reset();
    send_byte(8'hEC); send_byte(8'h55);
    send5(8'hEC, 8'h71, 8'hAA, 8'hBB, 8'h00);
    idle(6);
    chk(id_err_cnt == 1 && sync_drop_cnt == 1, "R5 id reject count", id_err_cnt, 1);
    chk(got_q.size() == 1 && got_q[0] == 17'h0BBAA, "R5 embedded record",
        got_q.size(), 1);

    // R6: illegal flag byte
    do_reset();
    send5(8'hEC, 8'h71, 8'h01, 8'h02, 8'h05);
    send5(8'hEC, 8'h71, 8'h03, 8'h04, 8'h01);
    idle(6);
    chk(flag_err_cnt == 1 && sync_drop_cnt == 4, "R6 flag reject count", flag_err_cnt, 1);
    chk(got_q.size() == 1 && got_q[0] == 17'h10403, "R6 following record",
        got_q.size(), 1);

    // R7: arrival during a drop and during an accept, no idle cycles
    do_reset();
    send_byte(8'h00);
    send5(8'hEC, 8'h71, 8'h78, 8'h56, 8'h00);
    send5(8'hEC, 8'h71, 8'hCD, 8'hAB, 8'h01);
    idle(6);
    chk(got_q.size() == 2, "R7 both records kept", got_q.size(), 2);
    if (got_q.size() == 2) begin
      chk(got_q[0] == 17'h05678, "R7 first record", int'(got_q[0]), 'h05678);
      chk(got_q[1] == 17'h1ABCD, "R7 second record", int'(got_q[1]), 'h1ABCD);
    end
    chk(sync_drop_cnt == 1, "R7 single drop", sync_drop_cnt, 1);

    // R10: data changes with valid low
    do_reset();
    for (int k = 0; k < 12; k++) begin
      in_data = (k % 2 == 0) ? 8'hEC : 8'h71;
      @(negedge clk);
    end
    send5(8'hEC, 8'h71, 8'h22, 8'h11, 8'h00);
    idle(6);
    chk(got_q.size() == 1 && sync_drop_cnt == 0 && id_err_cnt == 0,
        "R10 idle bytes ignored", got_q.size(), 1);

    // R9: reset in the middle of a record discards its bytes
    do_reset();
    send_byte(8'hEC); send_byte(8'h71); send_byte(8'h11);
    do_reset();
    send5(8'hEC, 8'h71, 8'h22, 8'h33, 8'h00);
    idle(6);
    chk(got_q.size() == 1 && got_q[0] == 17'h03322, "R9 stale bytes gone",
        got_q.size(), 1);
    chk(flag_err_cnt == 0 && id_err_cnt == 0, "R9 no error from stale bytes",
        flag_err_cnt, 0);

    // R8: saturation
    do_reset();
    for (int k = 0; k < CMAX + 7; k++) send_byte(8'h00);
    idle(6);
    chk(int'(sync_drop_cnt) == CMAX, "R8 counter saturates", sync_drop_cnt, CMAX);

    // random mix against the reference model
    do_reset();
    for (int n = 0; n < 90; n++) begin
      int kind;
      kind = int'($urandom % 6);
      case (kind)
        0, 1, 2: send5(8'hEC, 8'h71, 8'($urandom), 8'($urandom), 8'($urandom % 2));
        3: send5(8'hEC, 8'h72 + 8'($urandom % 100), 8'($urandom), 8'($urandom),
                 8'($urandom % 2));
        4: send5(8'hEC, 8'h71, 8'($urandom), 8'($urandom), 8'h02 + 8'($urandom % 200));
        default: begin
          int len;
          len = 1 + int'($urandom % 3);
          for (int j = 0; j < len; j++) send_byte(8'($urandom));
        end
      endcase
      idle(int'($urandom % 3));
    end
    idle(15);
    compare_model("R1 R7 random stream");

    finish_run();
  end

endmodule